// File: doc/BRIEF.md
# Bus Abort Debug Capture Registers

This block is a small bank of 16-bit registers. It records what happened when an access on a peripheral bus is aborted. The abort itself comes from elsewhere as a one-cycle pulse. The pulse arrives with the faulting byte address, the 32-bit data, the direction, the access size, the requester identity, and two cause bits: an access timeout and an access-width mismatch.

On the first abort the bank stores a snapshot of four registers:
- the low 16 bits of the word address;
- the low half of the data;
- the high half of the data;
- a flags word.

It then sets a valid bit. Later aborts cannot overwrite the snapshot until software writes 1 to the valid bit to release it.

The bank also holds the bridge configuration register and decodes it into three fields:
- an 8-bit timeout count;
- a timeout enable;
- two per-strobe posted-write enables.

Access goes through a single-cycle register port with a privilege input. Writes only take effect in supervisor mode. Reads work in any mode and are combinational.

Top module: `abort_dbg_regs`

## Requirements
- R1: After reset the address, data-low, data-high and flags registers read 0, the valid bit is 0, and the configuration register reads 0x01FF.
- R2: An abort pulse while valid is 0 captures the data into two registers, one cycle after the pulse. Data bits [15:0] go to offset 2 and bits [31:16] to offset 3. At the same edge, byte address bits [17:2] go to offset 1. Valid is set at that edge.
- R3: The flags register is at offset 4. Bit 0 is valid and bit 1 is the timeout cause. Bit 2 is the width-mismatch cause and bit 3 is the direction (1 = write). Bits [5:4] hold the access size and bits [9:6] the requester ID. The other bits read 0.
- R4: While valid is 1, further abort pulses leave all captured registers unchanged.
- R5: A supervisor write to offset 4 with bit 0 set clears valid. A write with bit 0 clear does nothing. The captured values remain readable after the clear.
- R6: A write with the privilege input low (user mode) changes no register, neither the configuration nor valid.
- R7: Reads return the same value in user and supervisor mode. Offsets 5 to 7 read 0.
- R8: The configuration register decodes as follows. Bits [7:0] are the timeout count and bit 8 is the timeout enable. Bits [10:9] are the posted-write enables for strobe 0 and strobe 1. Bits [15:11] read 0, and the fields drive the matching outputs.
- R9: If an abort and a supervisor clear land in the same cycle, the result depends on valid. With valid at 1, valid ends at 0 and nothing is captured. With valid at 0, the capture wins and valid ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_super_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from offset |
| abort_i | input | 1 | Abort pulse |
| abort_tmo_i | input | 1 | Abort cause: timeout |
| abort_width_i | input | 1 | Abort cause: width mismatch |
| abort_addr_i | input | 32 | Faulting byte address |
| abort_data_i | input | 32 | Access data |
| abort_wr_i | input | 1 | Access direction, 1 = write |
| abort_size_i | input | 2 | Access size code |
| abort_id_i | input | 4 | Requester ID |
| cfg_timeout_o | output | 8 | Decoded timeout count |
| cfg_tmo_en_o | output | 1 | Decoded timeout enable |
| cfg_post_en_o | output | 2 | Decoded posted-write enables per strobe |

## Verification
The assertions assume that every abort pulse carries at least one cause bit. The snapshot check after valid rises depends on this. They also assume the abort payload is stable during the pulse cycle.

The bench drives aborts only with a timeout, a width mismatch, or both. It changes abort inputs and register requests only just after a rising edge, so every pulse is one clean cycle. It hits the simultaneous-clear cases on purpose, to exercise the rule in R9.

// File: rtl/abort_dbg_pkg.sv
package abort_dbg_pkg;
  localparam int REG_W  = 16;
  localparam int RA_W   = 3;
  localparam int SIZE_W = 2;
  localparam int ID_W   = 4;
  localparam int TMO_W  = 8;
  localparam int POST_N = 2;

  typedef enum logic [RA_W-1:0] {
    RA_CFG   = 3'd0,
    RA_ADDR  = 3'd1,
    RA_DLO   = 3'd2,
    RA_DHI   = 3'd3,
    RA_FLAGS = 3'd4
  } reg_sel_e;

  localparam int FL_VALID = 0;
  localparam int FL_TMO   = 1;
  localparam int FL_WIDTH = 2;
  localparam int FL_WR    = 3;
  localparam int FL_SIZE  = 4;
  localparam int FL_ID    = FL_SIZE + SIZE_W;

  localparam int CF_EN    = TMO_W;
  localparam int CF_POST  = TMO_W + 1;
  localparam int CF_USED  = TMO_W + 1 + POST_N;

  typedef struct packed {
    logic              tmo;
    logic              width;
    logic              wr;
    logic [SIZE_W-1:0] size;
    logic [ID_W-1:0]   id;
  } abort_info_t;
endpackage

// File: rtl/abort_dbg_decode.sv
module abort_dbg_decode
  import abort_dbg_pkg::*;
(
  input  logic            req_i,
  input  logic            we_i,
  input  logic            super_i,
  input  logic [RA_W-1:0] addr_i,
  input  logic            wbit0_i,
  output logic            cfg_we_o,
  output logic            clr_o
);
  logic wr_ok;
  // R6: privilege gate on every write
  assign wr_ok    = req_i && we_i && super_i;
  assign cfg_we_o = wr_ok && (addr_i == RA_CFG);
  assign clr_o    = wr_ok && (addr_i == RA_FLAGS) && wbit0_i;
endmodule

// File: rtl/abort_dbg_cfg.sv
module abort_dbg_cfg
  import abort_dbg_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = 16'h01FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  cfg_o,
  output logic [TMO_W-1:0]  timeout_o,
  output logic              tmo_en_o,
  output logic [POST_N-1:0] post_en_o
);
  localparam logic [REG_W-1:0] USED_MASK = REG_W'((1 << CF_USED) - 1);

  logic [REG_W-1:0] cfg_q;

  // R8: reserved bits never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RST_VAL & USED_MASK;
    else if (we_i) cfg_q <= wdata_i & USED_MASK;
  end

  assign cfg_o     = cfg_q;
  assign timeout_o = cfg_q[TMO_W-1:0];
  assign tmo_en_o  = cfg_q[CF_EN];
  assign post_en_o = cfg_q[CF_POST +: POST_N];
endmodule

// File: rtl/abort_dbg_capture.sv
module abort_dbg_capture
  import abort_dbg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] data_i,
  input  abort_info_t       info_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [REG_W-1:0]  addr_o,
  output logic [REG_W-1:0]  dlo_o,
  output logic [REG_W-1:0]  dhi_o,
  output abort_info_t       info_o
);
  logic cap_en;
  logic valid_q;

  // R4: frozen while valid
  assign cap_en = abort_i && !valid_q;

  // R9: capture outranks clear; clear outranks hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= 1'b0;
    else if (cap_en) valid_q <= 1'b1;
    else if (clr_i)  valid_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dlo_o  <= '0;
      dhi_o  <= '0;
      info_o <= '0;
    end else if (cap_en) begin
      addr_o <= waddr_i;
      dlo_o  <= data_i[REG_W-1:0];
      dhi_o  <= data_i[DATA_W-1 -: REG_W];
      info_o <= info_i;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/abort_dbg_rdmux.sv
module abort_dbg_rdmux
  import abort_dbg_pkg::*;
(
  input  logic [RA_W-1:0]  addr_i,
  input  logic [REG_W-1:0] cfg_i,
  input  logic [REG_W-1:0] addr_reg_i,
  input  logic [REG_W-1:0] dlo_i,
  input  logic [REG_W-1:0] dhi_i,
  input  logic             valid_i,
  input  abort_info_t      info_i,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] flags;

  // R3: flags layout
  always_comb begin
    flags                     = '0;
    flags[FL_VALID]           = valid_i;
    flags[FL_TMO]             = info_i.tmo;
    flags[FL_WIDTH]           = info_i.width;
    flags[FL_WR]              = info_i.wr;
    flags[FL_SIZE +: SIZE_W]  = info_i.size;
    flags[FL_ID +: ID_W]      = info_i.id;
  end

  // R7: no privilege term on reads
  always_comb begin
    unique case (addr_i)
      RA_CFG:   rdata_o = cfg_i;
      RA_ADDR:  rdata_o = addr_reg_i;
      RA_DLO:   rdata_o = dlo_i;
      RA_DHI:   rdata_o = dhi_i;
      RA_FLAGS: rdata_o = flags;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/abort_dbg_regs.sv
module abort_dbg_regs
  import abort_dbg_pkg::*;
#(
  parameter int               ADDR_W  = 32,
  parameter int               DATA_W  = 32,
  parameter logic [REG_W-1:0] CFG_RST = 16'h01FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_super_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              abort_i,
  input  logic              abort_tmo_i,
  input  logic              abort_width_i,
  input  logic [ADDR_W-1:0] abort_addr_i,
  input  logic [DATA_W-1:0] abort_data_i,
  input  logic              abort_wr_i,
  input  logic [SIZE_W-1:0] abort_size_i,
  input  logic [ID_W-1:0]   abort_id_i,
  output logic [TMO_W-1:0]  cfg_timeout_o,
  output logic              cfg_tmo_en_o,
  output logic [POST_N-1:0] cfg_post_en_o
);
  localparam int WA_LSB = 2;
  localparam int WA_MSB = WA_LSB + REG_W - 1;

  logic             cfg_we, clr;
  logic [REG_W-1:0] cfg_q, cap_addr, cap_dlo, cap_dhi;
  logic             cap_valid;
  abort_info_t      info_in, cap_info;
  logic             unused_addr;

  assign unused_addr = ^{abort_addr_i[ADDR_W-1:WA_MSB+1], abort_addr_i[WA_LSB-1:0]};

  assign info_in = '{tmo: abort_tmo_i, width: abort_width_i, wr: abort_wr_i,
                     size: abort_size_i, id: abort_id_i};

  abort_dbg_decode u_dec (
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .super_i (reg_super_i),
    .addr_i  (reg_addr_i),
    .wbit0_i (reg_wdata_i[FL_VALID]),
    .cfg_we_o(cfg_we),
    .clr_o   (clr)
  );

  abort_dbg_cfg #(.RST_VAL(CFG_RST)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we),
    .wdata_i  (reg_wdata_i),
    .cfg_o    (cfg_q),
    .timeout_o(cfg_timeout_o),
    .tmo_en_o (cfg_tmo_en_o),
    .post_en_o(cfg_post_en_o)
  );

  // R2: word address bits only
  abort_dbg_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(abort_i),
    .waddr_i(abort_addr_i[WA_MSB:WA_LSB]),
    .data_i (abort_data_i),
    .info_i (info_in),
    .clr_i  (clr),
    .valid_o(cap_valid),
    .addr_o (cap_addr),
    .dlo_o  (cap_dlo),
    .dhi_o  (cap_dhi),
    .info_o (cap_info)
  );

  abort_dbg_rdmux u_rd (
    .addr_i    (reg_addr_i),
    .cfg_i     (cfg_q),
    .addr_reg_i(cap_addr),
    .dlo_i     (cap_dlo),
    .dhi_i     (cap_dhi),
    .valid_i   (cap_valid),
    .info_i    (cap_info),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: rtl/abort_dbg_chk.sv
module abort_dbg_chk
  import abort_dbg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_req_i,
  input logic             reg_we_i,
  input logic             reg_super_i,
  input logic [RA_W-1:0]  reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             abort_i,
  input logic [REG_W-1:0] abort_waddr_i,
  input logic             valid,
  input logic [REG_W-1:0] cap_addr,
  input logic [REG_W-1:0] cap_dlo,
  input logic [REG_W-1:0] cap_dhi,
  input abort_info_t      cap_info,
  input logic [REG_W-1:0] cfg_q
);
  logic sup_clr, user_wr;
  assign sup_clr = reg_req_i && reg_we_i && reg_super_i &&
                   (reg_addr_i == RA_FLAGS) && reg_wdata_i[0];
  assign user_wr = reg_req_i && reg_we_i && !reg_super_i;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !valid) |=> (valid && cap_addr == $past(abort_waddr_i)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && !sup_clr) |=> (valid && $stable(cap_addr) && $stable(cap_dlo) &&
                              $stable(cap_dhi) && $stable(cap_info)));

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && sup_clr) |=> !valid);

  a_r6_user_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_wr |=> $stable(cfg_q));

  a_r3_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid) |-> (cap_info.tmo || cap_info.width));

  a_r8_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_CFG) |-> (reg_rdata_o[REG_W-1:CF_USED] == '0));

  a_r7_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > RA_FLAGS) |-> (reg_rdata_o == '0));
endmodule

bind abort_dbg_regs abort_dbg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_req_i    (reg_req_i),
  .reg_we_i     (reg_we_i),
  .reg_super_i  (reg_super_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .abort_i      (abort_i),
  .abort_waddr_i(abort_addr_i[17:2]),
  .valid        (cap_valid),
  .cap_addr     (cap_addr),
  .cap_dlo      (cap_dlo),
  .cap_dhi      (cap_dhi),
  .cap_info     (cap_info),
  .cfg_q        (cfg_q)
);

// File: tb/tb_abort_dbg_regs.sv
`timescale 1ns/1ps
module tb_abort_dbg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 0, reg_we = 0, reg_super = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        abort = 0, a_tmo = 0, a_width = 0, a_wr = 0;
  logic [31:0] a_addr = 0, a_data = 0;
  logic [1:0]  a_size = 0;
  logic [3:0]  a_id = 0;
  logic [7:0]  cfg_timeout;
  logic        cfg_tmo_en;
  logic [1:0]  cfg_post_en;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  abort_dbg_regs dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_super_i(reg_super),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .abort_i(abort), .abort_tmo_i(a_tmo), .abort_width_i(a_width),
    .abort_addr_i(a_addr), .abort_data_i(a_data), .abort_wr_i(a_wr),
    .abort_size_i(a_size), .abort_id_i(a_id),
    .cfg_timeout_o(cfg_timeout), .cfg_tmo_en_o(cfg_tmo_en), .cfg_post_en_o(cfg_post_en)
  );

  function automatic logic [15:0] flags(bit v, bit t, bit w, bit wr, int sz, int id);
    return 16'(v) | (16'(t) << 1) | (16'(w) << 2) | (16'(wr) << 3) |
           (16'(sz) << 4) | (16'(id) << 6);
  endfunction

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rst_n && reg_req && !reg_we && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input bit sup, input logic [15:0] e, input string t);
    @(posedge clk); #1;
    reg_req = 1; reg_we = 0; reg_addr = a; reg_super = sup;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_req = 0;
  endtask

  task automatic wr(input logic [2:0] a, input bit sup, input logic [15:0] d);
    @(posedge clk); #1;
    reg_req = 1; reg_we = 1; reg_addr = a; reg_super = sup; reg_wdata = d;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0;
  endtask

  task automatic set_abort(input logic [31:0] ad, input logic [31:0] dt, input bit t,
                           input bit w, input bit dir, input int sz, input int id);
    abort = 1; a_addr = ad; a_data = dt; a_tmo = t; a_width = w;
    a_wr = dir; a_size = 2'(sz); a_id = 4'(id);
  endtask

  task automatic do_abort(input logic [31:0] ad, input logic [31:0] dt, input bit t,
                          input bit w, input bit dir, input int sz, input int id);
    @(posedge clk); #1;
    set_abort(ad, dt, t, w, dir, sz, id);
    @(posedge clk); #1;
    abort = 0;
  endtask

  task automatic chk_cfg(input logic [7:0] t, input bit en, input logic [1:0] p, input string tg);
    checks++;
    if (cfg_timeout !== t || cfg_tmo_en !== en || cfg_post_en !== p) begin
      errors++;
      $display("FAIL %s: cfg out=%h/%b/%b expected=%h/%b/%b", tg,
               cfg_timeout, cfg_tmo_en, cfg_post_en, t, en, p);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(0, 1, 16'h01FF, "R1 cfg reset");
    rd(1, 1, 16'h0000, "R1 addr reset");
    rd(2, 1, 16'h0000, "R1 dlo reset");
    rd(3, 1, 16'h0000, "R1 dhi reset");
    rd(4, 1, 16'h0000, "R1 flags reset");
    #1 chk_cfg(8'hFF, 1'b1, 2'b00, "R1 R8 cfg outputs at reset");

    // R2 R3 timeout abort, write, size 2, id 5
    do_abort(32'h0001_2344, 32'hDEAD_BEEF, 1, 0, 1, 2, 5);
    rd(1, 1, 16'h48D1, "R2 addr");
    rd(2, 1, 16'hBEEF, "R2 dlo");
    rd(3, 1, 16'hDEAD, "R2 dhi");
    rd(4, 1, flags(1, 1, 0, 1, 2, 5), "R3 flags timeout");

    // R4 later abort ignored
    do_abort(32'h0000_0100, 32'h1111_2222, 0, 1, 0, 1, 3);
    rd(1, 1, 16'h48D1, "R4 addr held");
    rd(2, 1, 16'hBEEF, "R4 dlo held");
    rd(4, 1, flags(1, 1, 0, 1, 2, 5), "R4 flags held");

    // R6 user writes ignored
    wr(4, 0, 16'h0001);
    rd(4, 0, flags(1, 1, 0, 1, 2, 5), "R6 user clear ignored");
    wr(0, 0, 16'h0123);
    rd(0, 0, 16'h01FF, "R6 user cfg write ignored");
    #1 chk_cfg(8'hFF, 1'b1, 2'b00, "R6 cfg outputs unchanged");

    // R5 clear semantics
    wr(4, 1, 16'hFFFE);
    rd(4, 1, flags(1, 1, 0, 1, 2, 5), "R5 write 0 no effect");
    wr(4, 1, 16'h0001);
    rd(4, 1, flags(0, 1, 0, 1, 2, 5), "R5 valid cleared");
    rd(1, 1, 16'h48D1, "R5 addr retained");

    // R3 width-mismatch abort, read, size 0, id 15
    do_abort(32'hFFFF_FFFC, 32'h1234_5678, 0, 1, 0, 0, 15);
    rd(1, 1, 16'hFFFF, "R2 addr high bits");
    rd(3, 0, 16'h1234, "R2 dhi user read");
    rd(4, 1, flags(1, 0, 1, 0, 0, 15), "R3 flags width");

    // R9 valid=1: clear and abort together -> cleared, no capture
    @(posedge clk); #1;
    reg_req = 1; reg_we = 1; reg_super = 1; reg_addr = 4; reg_wdata = 16'h0001;
    set_abort(32'h0000_0040, 32'hAAAA_5555, 1, 0, 1, 3, 1);
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0; abort = 0;
    rd(4, 1, flags(0, 0, 1, 0, 0, 15), "R9 clear wins when valid");
    rd(2, 1, 16'h5678, "R9 no capture when valid");

    // R9 valid=0: capture wins
    @(posedge clk); #1;
    reg_req = 1; reg_we = 1; reg_super = 1; reg_addr = 4; reg_wdata = 16'h0001;
    set_abort(32'h0000_0008, 32'h0000_0001, 1, 1, 1, 1, 2);
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0; abort = 0;
    rd(4, 1, flags(1, 1, 1, 1, 1, 2), "R9 capture wins when idle");
    rd(1, 1, 16'h0002, "R9 captured addr");

    // R8 cfg decode
    wr(0, 1, 16'hFFFF);
    rd(0, 1, 16'h07FF, "R8 reserved bits zero");
    #1 chk_cfg(8'hFF, 1'b1, 2'b11, "R8 outputs all set");
    wr(0, 1, 16'h0442);
    rd(0, 0, 16'h0442, "R8 readback user");
    #1 chk_cfg(8'h42, 1'b0, 2'b10, "R8 fields split");

    // R7 unmapped and mode-independent reads
    rd(5, 0, 16'h0000, "R7 offset 5");
    rd(7, 1, 16'h0000, "R7 offset 7");
    rd(4, 0, flags(1, 1, 1, 1, 1, 2), "R7 user flags read");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule